// File: doc/BRIEF.md
# External Memory Byte-Mode Access Sequencer

This block turns accesses from a 16-bit word-oriented CPU port into cycles on an external asynchronous memory bus. The external data bus is 8 or 16 bits wide. A two-bit byte-mode field in the block's control register selects whole-word, upper-byte-only or lower-byte-only transfers. That field and the bus-size input together decide three things: whether one CPU word access becomes one or two external cycles, which byte lane carries data, and how read data is placed back on the 16-bit CPU read bus.

The same byte-mode field also masks CPU accesses to the control register itself. As a result, in upper-byte mode the mode field cannot be rewritten, and only a reset leaves that mode. A CPU request is accepted only while the sequencer is idle, and completion is signalled by a one-cycle ready pulse. Each external cycle is one clock with the strobe low followed by one clock with the strobe high.

Top module: `ext_byte_seq`

## Requirements
- R1: After reset the mode field is 00 (word), a register read returns 16'h0000, `mem_strobe_n` is high and `cpu_ready` is low.
- R2: Register bits 15:2 always read as zero and ignore writes; the mode field sits in bits 1:0.
- R3: Register accesses are masked by the current mode. Mode 00 reaches bits 15:0. Mode 01 reaches only bits 15:8: a write leaves the mode unchanged and a read returns 0. Mode 10 reaches only bits 7:0, and unreached read bits return 0.
- R4: A register access (`cpu_reg_sel`=1) raises `cpu_ready` in the first cycle after acceptance and starts no external cycle.
- R5: With word mode on a 16-bit bus, a CPU access makes one external cycle at byte address 2*`cpu_addr` with `mem_lane_en`=2'b11. `cpu_ready` rises in the third cycle after acceptance.
- R6: With word mode on an 8-bit bus, a CPU access makes two cycles. The first is at the even byte address and carries CPU bits 7:0. The second is at the odd address (+1) and carries bits 15:8. Each cycle has `mem_lane_en`=2'b01 and uses `mem_wdata[7:0]`/`mem_rdata[7:0]`. Read data is assembled as {second byte, first byte}, and `cpu_ready` rises in the fifth cycle after acceptance.
- R7: With a byte mode on a 16-bit bus, a CPU access makes one cycle at the even byte address. Upper mode uses `mem_lane_en`=2'b10 and lower mode uses 2'b01. Read data keeps only the selected lane and returns 0 in the other.
- R8: With a byte mode on an 8-bit bus, a CPU access makes one cycle on lane 7:0 with `mem_lane_en`=2'b01. Upper mode uses the odd address and CPU bits 15:8, and its read byte returns in CPU bits 15:8. Lower mode uses the even address and bits 7:0, and its read byte returns in bits 7:0. In both cases the other CPU read lane is 0.
- R9: `bus_size`=2'b00 selects the 8-bit bus; every other value selects the 16-bit bus.
- R10: The reserved mode 11 behaves exactly like word mode, both for external and for register accesses.
- R11: Each external cycle holds `mem_strobe_n` low for exactly one clock and then high for one clock. `mem_we` is high only during the strobe-low clock of a write. `cpu_ready` is never high while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Request; accepted only when idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_reg_sel | input | 1 | 1 = access the control register, 0 = external memory |
| cpu_addr | input | ADDR_W | CPU word address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| bus_size | input | 2 | 00 = 8-bit bus, other = 16-bit bus |
| mem_addr | output | ADDR_W+1 | External byte address |
| mem_strobe_n | output | 1 | Active-low cycle strobe |
| mem_we | output | 1 | Write enable during strobe |
| mem_lane_en | output | 2 | Byte-lane enables, bit 1 = bits 15:8 |
| mem_wdata | output | 16 | External write data |
| mem_rdata | input | 16 | External read data |

## Verification
The bench builds the block with ADDR_W=4, so the whole 16-word address space is swept. It covers every combination of the four bus-size codes, the four mode codes, read and write, and every word address. This brings the reserved mode and the aliased bus-size codes into the same sweep as the normal settings. A directed sequence walks the register through modes written under word, lower-byte and upper-byte masking, and observes each resulting mode through the lanes of a following external cycle.

// File: rtl/ext_byte_seq.sv
module ext_byte_seq #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_reg_sel,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [15:0]       cpu_wdata,
  output logic [15:0]       cpu_rdata,
  output logic              cpu_ready,
  input  logic [1:0]        bus_size,
  output logic [ADDR_W:0]   mem_addr,
  output logic              mem_strobe_n,
  output logic              mem_we,
  output logic [1:0]        mem_lane_en,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_STRB, S_RECOV} st_t;

  st_t               st;
  logic [1:0]        mode_q, xmode;
  logic              narrow, second, we_q, ready_q;
  logic [ADDR_W-1:0] waddr;
  logic [15:0]       wbuf, rd_q;

  wire [1:0]  eff      = (mode_q == 2'b11) ? 2'b00 : mode_q;
  wire        accept   = cpu_req && (st == S_IDLE);
  wire        split    = narrow && (xmode == 2'b00);
  wire        last     = !split || second;
  wire        hi_cyc   = narrow && ((xmode == 2'b01) || (xmode == 2'b00 && second));
  wire [15:0] acc_mask = (eff == 2'b01) ? 16'hFF00 : (eff == 2'b10) ? 16'h00FF : 16'hFFFF;
  wire [15:0] reg_view = {14'b0, mode_q} & acc_mask;

  assign mem_addr     = {waddr, hi_cyc};
  assign mem_strobe_n = (st != S_STRB);
  assign mem_we       = we_q && (st == S_STRB);
  assign mem_lane_en  = narrow ? 2'b01 :
                        (xmode == 2'b01) ? 2'b10 :
                        (xmode == 2'b10) ? 2'b01 : 2'b11;
  assign mem_wdata    = narrow ? {8'h00, hi_cyc ? wbuf[15:8] : wbuf[7:0]} : wbuf;

  wire [15:0] lane_in = narrow ? (hi_cyc ? {mem_rdata[7:0], 8'h00} : {8'h00, mem_rdata[7:0]})
                               : (mem_rdata & {{8{mem_lane_en[1]}}, {8{mem_lane_en[0]}}});

  assign cpu_rdata = rd_q;
  assign cpu_ready = ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      mode_q  <= 2'b00;
      xmode   <= 2'b00;
      narrow  <= 1'b0;
      second  <= 1'b0;
      we_q    <= 1'b0;
      waddr   <= '0;
      wbuf    <= '0;
      rd_q    <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          if (cpu_reg_sel) begin
            ready_q <= 1'b1;
            rd_q    <= cpu_we ? 16'h0000 : reg_view;
            if (cpu_we && eff != 2'b01) mode_q <= cpu_wdata[1:0];
          end else begin
            st     <= S_STRB;
            xmode  <= eff;
            narrow <= (bus_size == 2'b00);
            second <= 1'b0;
            we_q   <= cpu_we;
            waddr  <= cpu_addr;
            wbuf   <= cpu_wdata;
            rd_q   <= '0;
          end
        end
        S_STRB: begin
          st <= S_RECOV;
          if (!we_q) rd_q <= rd_q | lane_in;
        end
        S_RECOV: begin
          if (last) begin
            st      <= S_IDLE;
            ready_q <= 1'b1;
          end else begin
            second <= 1'b1;
            st     <= S_STRB;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ext_byte_seq_chk.sv
module ext_byte_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_strobe_n,
  input logic       mem_we,
  input logic       cpu_ready,
  input logic [1:0] mem_lane_en,
  input logic       addr_lsb,
  input logic       narrow,
  input logic       second,
  input logic [1:0] xmode,
  input logic [1:0] mode_q,
  input logic [1:0] eff,
  input logic       accept,
  input logic       cpu_reg_sel,
  input logic       cpu_we
);

  // R11
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_strobe_n |=> mem_strobe_n);

  // R11
  ready_not_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_strobe_n |-> !cpu_ready);

  // R11
  we_only_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !mem_strobe_n);

  // R6
  narrow_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_strobe_n && narrow) |-> (mem_lane_en == 2'b01));

  // R6
  second_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_strobe_n && second) |-> addr_lsb);

  // R7
  wide_high_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_strobe_n && !narrow && xmode == 2'b01) |-> (mem_lane_en == 2'b10));

  // R3
  high_mode_reg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cpu_reg_sel && cpu_we && eff == 2'b01) |=> $stable(mode_q));

endmodule

bind ext_byte_seq ext_byte_seq_chk chk (
  .clk(clk), .rst_n(rst_n), .mem_strobe_n(mem_strobe_n), .mem_we(mem_we),
  .cpu_ready(cpu_ready), .mem_lane_en(mem_lane_en), .addr_lsb(mem_addr[0]),
  .narrow(narrow), .second(second), .xmode(xmode), .mode_q(mode_q), .eff(eff),
  .accept(accept), .cpu_reg_sel(cpu_reg_sel), .cpu_we(cpu_we)
);

// File: tb/ext_byte_seq_test.sv
`timescale 1ns/1ps
module ext_byte_seq_test;
  localparam int AW = 4;

  logic          clk = 0, rst_n = 0;
  logic          cpu_req = 0, cpu_we = 0, cpu_reg_sel = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [15:0]   cpu_wdata = '0;
  logic [15:0]   cpu_rdata;
  logic          cpu_ready;
  logic [1:0]    bus_size = 2'b01;
  logic [AW:0]   mem_addr;
  logic          mem_strobe_n, mem_we;
  logic [1:0]    mem_lane_en;
  logic [15:0]   mem_wdata, mem_rdata;

  ext_byte_seq #(.ADDR_W(AW)) uut (.*);

  always #10 clk = ~clk;

  function automatic logic [7:0] lo_b(int a); return 8'((a * 5 + 23) & 255); endfunction
  function automatic logic [7:0] hi_b(int a); return 8'((a * 3 + 145) & 255); endfunction
  assign mem_rdata = {hi_b(int'(mem_addr)), lo_b(int'(mem_addr))};

  int errors = 0, checks = 0, nlog = 0;
  logic [AW:0]  la [8];
  logic [1:0]   ll [8];
  logic         lw [8];
  logic [15:0]  ld [8];

  always @(posedge clk) if (rst_n && !mem_strobe_n) begin
    la[nlog % 8] <= mem_addr; ll[nlog % 8] <= mem_lane_en;
    lw[nlog % 8] <= mem_we;   ld[nlog % 8] <= mem_wdata;
    nlog <= nlog + 1;
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int lat, base, ncyc;
  logic [15:0] rdv;

  task automatic access(bit rs, bit we, logic [AW-1:0] a, logic [15:0] wd);
    @(negedge clk);
    base = nlog;
    cpu_req = 1; cpu_reg_sel = rs; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    cpu_req = 0;
    lat = 1;
    while (!cpu_ready && lat < 20) begin @(negedge clk); lat++; end
    rdv = cpu_rdata;
    ncyc = nlog - base;
  endtask

  task automatic do_reset(logic [1:0] bs);
    @(negedge clk);
    rst_n = 0; bus_size = bs;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic ext_check(logic [1:0] bs, logic [1:0] m, bit we, int w, logic [15:0] wd);
    bit nar = (bs == 2'b00);
    logic [1:0] em = (m == 2'b11) ? 2'b00 : m;
    int ec = (nar && em == 2'b00) ? 2 : 1;
    int a0 = 2 * w;
    int ea [2]; logic [15:0] ed [2]; logic [1:0] el; logic [15:0] er;
    access(0, we, AW'(w), wd);
    el = nar ? 2'b01 : (em == 2'b01 ? 2'b10 : em == 2'b10 ? 2'b01 : 2'b11);
    if (nar) begin
      ea[0] = (em == 2'b01) ? a0 + 1 : a0;            ea[1] = a0 + 1;
      ed[0] = {8'h00, (em == 2'b01) ? wd[15:8] : wd[7:0]}; ed[1] = {8'h00, wd[15:8]};
      er = (em == 2'b00) ? {lo_b(a0 + 1), lo_b(a0)} :
           (em == 2'b01) ? {lo_b(a0 + 1), 8'h00} : {8'h00, lo_b(a0)};
    end else begin
      ea[0] = a0; ea[1] = a0; ed[0] = wd; ed[1] = wd;
      er = (em == 2'b00) ? {hi_b(a0), lo_b(a0)} :
           (em == 2'b01) ? {hi_b(a0), 8'h00} : {8'h00, lo_b(a0)};
    end
    // R5 R6 R7 R8 R9 R10: cycle count and latency
    check(ncyc == ec, nar ? "R6/R8 cycle count" : "R5/R7 cycle count", ncyc, ec);
    check(lat == 2 * ec + 1, "R5/R6 ready latency", lat, 2 * ec + 1);
    for (int i = 0; i < ec && i < ncyc; i++) begin
      check(int'(la[(base + i) % 8]) == ea[i], "R6/R8 address", int'(la[(base + i) % 8]), ea[i]);
      check(ll[(base + i) % 8] == el, "R7/R9 lane enable", ll[(base + i) % 8], el);
      check(lw[(base + i) % 8] == we, "R11 write enable", lw[(base + i) % 8], we);
      if (we) check(ld[(base + i) % 8] == ed[i], "R6/R8 write data", ld[(base + i) % 8], ed[i]);
    end
    if (!we) check(rdv == er, "R7/R8/R10 read data", rdv, er);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset(2'b01);
    @(negedge clk);
    // R1 reset state
    check(mem_strobe_n == 1'b1, "R1 strobe idle", mem_strobe_n, 1);
    check(cpu_ready == 1'b0, "R1 ready low", cpu_ready, 0);
    access(1, 0, '0, '0);
    check(rdv == 16'h0000, "R1 reset register", rdv, 0);
    // R4 register latency, no external cycle
    check(lat == 1 && ncyc == 0, "R4 register access timing", lat * 16 + ncyc, 16);
    // R2 reserved bits
    access(1, 1, '0, 16'hFFFF);
    access(1, 0, '0, '0);
    check(rdv == 16'h0003, "R2 reserved read zero", rdv, 16'h0003);
    // R10 mode 11 behaves as word: full write to mode 10
    access(1, 1, '0, 16'hFFFE);
    access(1, 0, '0, '0);
    check(rdv == 16'h0002, "R3 low-mode register read", rdv, 16'h0002);
    // R3 low mode write reaches bits 7:0: switch to mode 01
    access(1, 1, '0, 16'hAB01);
    access(1, 0, '0, '0);
    check(rdv == 16'h0000, "R3 high-mode register read", rdv, 0);
    access(0, 0, 4'd3, '0);
    check(ll[base % 8] == 2'b10, "R3 mode now high byte", ll[base % 8], 2'b10);
    // R3 high mode write ignored on bits 1:0
    access(1, 1, '0, 16'hFFFC);
    access(0, 0, 4'd5, '0);
    check(ll[base % 8] == 2'b10, "R3 high-mode write ignored", ll[base % 8], 2'b10);

    for (int bs = 0; bs < 4; bs++)
      for (int m = 0; m < 4; m++) begin
        do_reset(2'(bs));
        access(1, 1, '0, 16'hFFFC | 16'(m));
        access(1, 0, '0, '0);
        check(rdv == ((m == 1) ? 16'h0 : 16'(m)), "R2/R3/R10 mode readback", rdv,
              (m == 1) ? 0 : m);
        for (int we = 0; we < 2; we++)
          for (int w = 0; w < 16; w++)
            ext_check(2'(bs), 2'(m), we[0], w, 16'((w * 4369 + 16'h5A3C) ^ (m << 6)));
      end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule